// File: doc/BRIEF.md
# Channel Word Transfer Unit

This block carries out the word-level operations of a single time-multiplexed I/O channel. It holds a two-word channel record. The first word is a control word made of a supervisory code, an opcode and an operand. The second word is a 32-bit data word. A device offers one input word per cycle on `dev_word`, qualified by `dev_valid`. Depending on the opcode, the block either captures that word into the data word or answers with the data word on the output port.

A store or a load can be unconditional. It can also depend on the input word being nonzero, or on the input lying outside an unsigned window whose two limits are packed into the operand. When a conditional operation actually moves data, the block raises a one-cycle `event_o` pulse so that a program can be notified.

Operations run only while the supervisory code grants control to the device. In every other supervisory state the block reports not-ready and leaves the record untouched. The record is written through the `cfg_*` port.

Top module: `chan_word_xfer`

## Requirements
- R1: While `rst_n` is low, the control word and the data word are zero and `out_valid`, `out_word` and `event_o` are zero. A zero control word means that `not_ready` reads 1.
- R2: When `cfg_we` is high at a clock edge, `cfg_ctrl` becomes the control word and `cfg_data` becomes the data word. In that same cycle `dev_valid` is ignored.
- R3: The control word has the supervisory code in bits [31:30], the opcode in bits [29:26] and the operand in bits [25:0]. `not_ready` is 1 unless the supervisory code is 10. While `not_ready` is 1, a valid input changes nothing and produces no output and no event.
- R4: Opcode 0100 copies every valid input into the data word at the next edge and raises no event.
- R5: Opcode 0110 copies a valid input into the data word only if the input is nonzero. A copy that happens raises `event_o` in the following cycle.
- R6: Opcode 0101 copies a valid input only if it is outside the window, and a copy raises `event_o`. The lower limit is operand bits [25:13] and the upper limit is operand bits [12:0]. Both are unsigned. The input is outside the window when it is strictly below the lower limit or strictly above the upper limit.
- R7: Opcode 1100 answers every valid input in the next cycle with `out_valid`=1 and `out_word` equal to the data word. It raises no event.
- R8: Opcode 1110 loads only for a nonzero input, and opcode 1101 loads only for an input outside the window of R6. A load that happens raises `event_o` together with `out_valid`.
- R9: In any cycle without a load, `out_valid` is 0 and `out_word` is all zero.
- R10: Opcode 0000 and every opcode not listed here neither store nor load, and they raise no event.
- R11: `event_o` is high for exactly one cycle per transferring input, and only in the cycle after a valid input was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Record write strobe |
| cfg_ctrl | input | 32 | Control word to write |
| cfg_data | input | 32 | Data word to write |
| dev_valid | input | 1 | Device input word present |
| dev_word | input | 32 | Device input word |
| not_ready | output | 1 | Device is not in control |
| out_valid | output | 1 | Load performed last cycle |
| out_word | output | 32 | Loaded word, zero when no load |
| event_o | output | 1 | Conditional transfer pulse |
| rec_data | output | 32 | Current data word |

## Verification
The assertions assume that `rst_n` is held low through at least one clock edge before any activity, and that inputs change only between edges. They also assume that a record write and a device word may coincide, in which case the write wins. The stimulus drives inputs on the falling edge and rewrites the record at random intervals, sometimes in the same cycle as a valid device word. It also biases input words toward zero and toward values on either side of each limit, so that the strict-inequality boundaries are hit often.

// File: rtl/cwx_pkg.sv
package cwx_pkg;

  localparam logic [1:0] SUP_DEVICE = 2'b10;

  typedef enum logic [3:0] {
    OP_IDLE   = 4'b0000,
    OP_ST_ALL = 4'b0100,
    OP_ST_NZ  = 4'b0110,
    OP_ST_WIN = 4'b0101,
    OP_LD_ALL = 4'b1100,
    OP_LD_NZ  = 4'b1110,
    OP_LD_WIN = 4'b1101
  } op_e;

  typedef struct packed {
    logic do_store;
    logic do_load;
    logic need_nz;
    logic need_out;
  } op_dec_t;

endpackage

// File: rtl/cwx_decode.sv
module cwx_decode
  import cwx_pkg::*;
(
  input  logic [3:0] opcode,
  output op_dec_t    dec
);
  always_comb begin
    dec = '0;
    case (opcode)
      OP_ST_ALL: dec.do_store = 1'b1;
      OP_ST_NZ:  begin dec.do_store = 1'b1; dec.need_nz  = 1'b1; end
      OP_ST_WIN: begin dec.do_store = 1'b1; dec.need_out = 1'b1; end
      OP_LD_ALL: dec.do_load = 1'b1;
      OP_LD_NZ:  begin dec.do_load = 1'b1; dec.need_nz  = 1'b1; end
      OP_LD_WIN: begin dec.do_load = 1'b1; dec.need_out = 1'b1; end
      default:   dec = '0;
    endcase
  end
endmodule

// File: rtl/cwx_qual.sv
module cwx_qual #(
  parameter int DATA_W = 32,
  parameter int LIM_W  = 13
) (
  input  logic [DATA_W-1:0] din,
  input  logic [LIM_W-1:0]  lim_lo,
  input  logic [LIM_W-1:0]  lim_hi,
  output logic              is_nz,
  output logic              is_outside
);
  logic [DATA_W-1:0] lo_ext, hi_ext;

  always_comb begin
    lo_ext     = DATA_W'(lim_lo);
    hi_ext     = DATA_W'(lim_hi);
    is_nz      = |din;
    is_outside = (din < lo_ext) || (din > hi_ext);
  end
endmodule

// File: rtl/chan_word_xfer.sv
module chan_word_xfer
  import cwx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OPND_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OPND_W+5:0] cfg_ctrl,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_word,
  output logic              not_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word,
  output logic              event_o,
  output logic [DATA_W-1:0] rec_data
);
  localparam int CTRL_W = OPND_W + 6;
  localparam int LIM_W  = OPND_W / 2;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ov_q, ov_d, ev_q, ev_d;
  logic [DATA_W-1:0] ow_q, ow_d;

  logic [1:0]        sup;
  logic [3:0]        opcode;
  logic [OPND_W-1:0] operand;
  op_dec_t           dec;
  logic              is_nz, is_outside, qual_ok, run, st_fire, ld_fire;

  assign sup     = ctrl_q[CTRL_W-1 -: 2];
  assign opcode  = ctrl_q[CTRL_W-3 -: 4];
  assign operand = ctrl_q[OPND_W-1:0];

  cwx_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  cwx_qual #(.DATA_W(DATA_W), .LIM_W(LIM_W)) u_qual (
    .din        (dev_word),
    .lim_lo     (operand[2*LIM_W-1 -: LIM_W]),
    .lim_hi     (operand[LIM_W-1:0]),
    .is_nz      (is_nz),
    .is_outside (is_outside)
  );

  always_comb begin
    run     = dev_valid && !cfg_we && (sup == SUP_DEVICE);
    qual_ok = (!dec.need_nz || is_nz) && (!dec.need_out || is_outside);
    st_fire = run && dec.do_store && qual_ok;
    ld_fire = run && dec.do_load && qual_ok;

    ctrl_d = ctrl_q;
    data_d = data_q;
    if (cfg_we) begin
      ctrl_d = cfg_ctrl;
      data_d = cfg_data;
    end else if (st_fire) begin
      data_d = dev_word;
    end

    ov_d = ld_fire;
    ow_d = ld_fire ? data_q : '0;
    ev_d = (st_fire || ld_fire) && (dec.need_nz || dec.need_out);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      ov_q   <= 1'b0;
      ow_q   <= '0;
      ev_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
      ov_q   <= ov_d;
      ow_q   <= ow_d;
      ev_q   <= ev_d;
    end
  end

  assign not_ready = (sup != SUP_DEVICE);
  assign out_valid = ov_q;
  assign out_word  = ow_q;
  assign event_o   = ev_q;
  assign rec_data  = data_q;

  // R3
  hold_when_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && not_ready && !cfg_we) |=> (!out_valid && !event_o && $stable(rec_data)));

  // R9
  idle_out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_word == '0));

  // R11
  event_after_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(dev_valid && !cfg_we && !not_ready));

  // R4
  store_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !cfg_we && !not_ready && opcode == OP_ST_ALL)
      |=> (rec_data == $past(dev_word) && !event_o && !out_valid));

  // R7
  load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !cfg_we && !not_ready && opcode == OP_LD_ALL)
      |=> (out_valid && out_word == $past(rec_data) && !event_o));

  // R10
  idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !cfg_we && !not_ready && opcode == OP_IDLE)
      |=> ($stable(rec_data) && !out_valid && !event_o));

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (rec_data == $past(cfg_data) && !out_valid && !event_o));
endmodule

// File: tb/chan_word_xfer_tb.sv
module chan_word_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_ctrl, cfg_data;
  logic        dev_valid;
  logic [31:0] dev_word;
  logic        not_ready, out_valid, event_o;
  logic [31:0] out_word, rec_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // behavioural reference state
  logic [31:0] m_ctrl, m_data, m_ow;
  logic        m_ov, m_ev;

  always #5 clk = ~clk;

  chan_word_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
    .cfg_data(cfg_data), .dev_valid(dev_valid), .dev_word(dev_word),
    .not_ready(not_ready), .out_valid(out_valid), .out_word(out_word),
    .event_o(event_o), .rec_data(rec_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_data = 0; m_ov = 0; m_ow = 0; m_ev = 0;
    end else begin
      logic [31:0] lo, hi;
      bit nz, outw, cond;
      m_ov = 0; m_ow = 0; m_ev = 0;
      if (cfg_we) begin
        m_ctrl = cfg_ctrl;
        m_data = cfg_data;
      end else if (dev_valid && m_ctrl[31:30] == 2'd2) begin
        lo   = {19'd0, m_ctrl[25:13]};
        hi   = {19'd0, m_ctrl[12:0]};
        nz   = (dev_word != 0);
        outw = (dev_word < lo) || (dev_word > hi);
        case (m_ctrl[29:26])
          4'b0100: m_data = dev_word;
          4'b0110: if (nz)   begin m_data = dev_word; m_ev = 1; end
          4'b0101: if (outw) begin m_data = dev_word; m_ev = 1; end
          4'b1100: begin m_ov = 1; m_ow = m_data; end
          4'b1110: if (nz)   begin m_ov = 1; m_ow = m_data; m_ev = 1; end
          4'b1101: if (outw) begin m_ov = 1; m_ow = m_data; m_ev = 1; end
          default: cond = 0;
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(not_ready == (m_ctrl[31:30] != 2'd2), "R3 not_ready", {31'd0, not_ready}, {31'd0, m_ctrl[31:30] != 2'd2});
      check(rec_data == m_data, "R4 data word", rec_data, m_data);
      check(out_valid == m_ov, "R8 out_valid", {31'd0, out_valid}, {31'd0, m_ov});
      check(out_word == m_ow, "R9 out_word", out_word, m_ow);
      check(event_o == m_ev, "R11 event", {31'd0, event_o}, {31'd0, m_ev});
    end
  end

  function automatic logic [31:0] mk(input logic [1:0] s, input logic [3:0] op, input logic [25:0] opnd);
    return {s, op, opnd};
  endfunction

  task automatic cfg(input logic [31:0] c, input logic [31:0] d);
    cfg_we = 1; cfg_ctrl = c; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic feed(input logic [31:0] w);
    dev_valid = 1; dev_word = w;
    @(negedge clk);
    dev_valid = 0;
  endtask

  // window: lower 100, upper 200
  localparam logic [25:0] WIN = {13'd100, 13'd200};

  initial begin
    #1_500_000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_ctrl = 0; cfg_data = 0; dev_valid = 0; dev_word = 0;
    repeat (3) @(negedge clk);
    // R1
    check(not_ready && !out_valid && !event_o && out_word == 0 && rec_data == 0, "R1 reset", rec_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: program in control, nothing happens
    cfg(mk(2'b01, 4'b0100, 0), 32'h1111);
    feed(32'hABCD);
    check(rec_data == 32'h1111, "R3 held", rec_data, 32'h1111);
    cfg(mk(2'b11, 4'b1100, 0), 32'h1111);
    feed(32'h5);
    check(!out_valid && not_ready, "R3 load blocked", {31'd0, out_valid}, 0);

    // R4
    cfg(mk(2'b10, 4'b0100, 0), 32'h0);
    feed(32'hDEAD_BEEF);
    check(rec_data == 32'hDEAD_BEEF && !event_o, "R4 store", rec_data, 32'hDEAD_BEEF);

    // R5
    cfg(mk(2'b10, 4'b0110, 0), 32'h77);
    feed(32'h0);
    check(rec_data == 32'h77 && !event_o, "R5 zero skipped", rec_data, 32'h77);
    feed(32'h9);
    check(rec_data == 32'h9 && event_o, "R5 nonzero stored", rec_data, 32'h9);

    // R6 boundaries
    cfg(mk(2'b10, 4'b0101, WIN), 32'h55);
    feed(32'd100);
    check(rec_data == 32'h55, "R6 at lower", rec_data, 32'h55);
    feed(32'd200);
    check(rec_data == 32'h55, "R6 at upper", rec_data, 32'h55);
    feed(32'd99);
    check(rec_data == 32'd99 && event_o, "R6 below", rec_data, 32'd99);
    feed(32'd201);
    check(rec_data == 32'd201 && event_o, "R6 above", rec_data, 32'd201);

    // R7
    cfg(mk(2'b10, 4'b1100, 0), 32'hCAFE_F00D);
    feed(32'h0);
    check(out_valid && out_word == 32'hCAFE_F00D && !event_o, "R7 load", out_word, 32'hCAFE_F00D);
    @(negedge clk);
    // R9
    check(!out_valid && out_word == 0, "R9 idle zero", out_word, 0);

    // R8
    cfg(mk(2'b10, 4'b1110, 0), 32'h1234);
    feed(32'h0);
    check(!out_valid && out_word == 0, "R8 nz skipped", out_word, 0);
    feed(32'h1);
    check(out_valid && out_word == 32'h1234 && event_o, "R8 nz load", out_word, 32'h1234);
    cfg(mk(2'b10, 4'b1101, WIN), 32'h4321);
    feed(32'd150);
    check(!out_valid && !event_o, "R8 inside skipped", out_word, 0);
    feed(32'hFFFF_FFFF);
    check(out_valid && out_word == 32'h4321 && event_o, "R8 outside load", out_word, 32'h4321);

    // R10
    cfg(mk(2'b10, 4'b0000, 0), 32'hAAAA);
    feed(32'h5);
    check(rec_data == 32'hAAAA && !out_valid && !event_o, "R10 nop", rec_data, 32'hAAAA);
    cfg(mk(2'b10, 4'b0111, 0), 32'hAAAA);
    feed(32'h5);
    check(rec_data == 32'hAAAA && !out_valid, "R10 unlisted", rec_data, 32'hAAAA);

    // R2: write wins over a coincident input
    cfg_we = 1; cfg_ctrl = mk(2'b10, 4'b0100, 0); cfg_data = 32'h2222;
    dev_valid = 1; dev_word = 32'h3333;
    @(negedge clk);
    cfg_we = 0; dev_valid = 0;
    check(rec_data == 32'h2222, "R2 write priority", rec_data, 32'h2222);

    // R11: event is a single-cycle pulse
    cfg(mk(2'b10, 4'b0110, 0), 0);
    feed(32'h8);
    check(event_o, "R11 pulse high", {31'd0, event_o}, 1);
    @(negedge clk);
    check(!event_o, "R11 pulse low", {31'd0, event_o}, 0);

    // mixed random traffic, compared each clock by the model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ops [7];
      int sel;
      ops = '{4'b0000, 4'b0100, 4'b0110, 4'b0101, 4'b1100, 4'b1110, 4'b1101};
      cfg_we = ($urandom_range(0, 15) == 0);
      cfg_ctrl = mk(($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b10,
                    ops[$urandom_range(0, 6)], WIN);
      cfg_data = $urandom;
      dev_valid = ($urandom_range(0, 3) != 0);
      sel = $urandom_range(0, 5);
      case (sel)
        0: dev_word = 0;
        1: dev_word = 32'd99 + $urandom_range(0, 2);
        2: dev_word = 32'd199 + $urandom_range(0, 2);
        3: dev_word = $urandom_range(0, 300);
        default: dev_word = $urandom;
      endcase
      @(negedge clk);
    end
    cfg_we = 0; dev_valid = 0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule